// File: doc/BRIEF.md
# GMII ARP/UDP Receive Frame Parser

This block sits behind a gigabit PHY's byte-wide GMII receive port, running in the 125 MHz receive clock domain. It waits for a frame's preamble and start delimiter, counts the bytes that follow and sorts the frame into one of three kinds: an address-resolution request for this node, a UDP datagram over IPv4 addressed to this node, or something to ignore. While the frame streams in, it keeps the peer's MAC address, the peer's IPv4 address and both UDP ports. It also runs the IPv4 header checksum and the Ethernet CRC-32 on the fly.

UDP payload bytes go to an external payload buffer through a write port as they arrive. The buffer is a ring: the parser owns the committed head pointer and a downstream reader returns its read pointer. The payload is written before the frame has been verified. When the frame ends, the parser makes its decision in a single cycle. A good ARP request raises a one-cycle reply request for the transmit side. A good datagram raises a one-cycle ready pulse, publishes the payload length and advances the head pointer. Any failure discards the speculative writes, because the internal write pointer rolls back to the head. The peer fields are only updated by an accepted frame, so the transmit side can reuse them when it builds replies.

Top module: `gmii_udp_rx`

## Requirements
- R1: A frame begins with one or more 0x55 bytes followed by 0xD5. Byte index 0 is the first byte after 0xD5. A frame in which any other value comes before 0xD5 is ignored completely.
- R2: Bytes 12..13 (big-endian) select the frame kind: 0x0806 is ARP and 0x0800 is IPv4. Any other value leads to no pulse, no field update and no head movement.
- R3: An ARP frame is accepted only if the opcode in bytes 20..21 is 1, the target IP in bytes 38..41 equals `local_ip`, and the frame has at least 46 bytes. `arp_req` then pulses for one cycle, on the clock edge after the first cycle with `gmii_rx_dv` low. `peer_mac` takes bytes 6..11 and `peer_ip` takes bytes 28..31.
- R4: An IPv4 frame is accepted as UDP only if all of these hold: byte 14 is 0x45, byte 23 is 17, the destination IP in bytes 30..33 equals `local_ip`, and the ones'-complement sum of the 16-bit words in bytes 14..33 is 0xFFFF. `udp_rdy` then pulses for one cycle with the same timing as in R3. `peer_mac` takes bytes 6..11, `peer_ip` takes bytes 26..29, `peer_port` takes bytes 34..35, `local_port` takes bytes 36..37, and `pay_len` is the UDP length in bytes 38..39 minus 8.
- R5: The last four bytes are the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, final inversion), sent least significant byte first. A frame with a wrong CRC is rejected.
- R6: A frame is rejected if `gmii_rx_er` is high together with `gmii_rx_dv` on any byte after the start delimiter.
- R7: Payload bytes, starting at byte 42, are written in order to consecutive buffer addresses beginning at `buf_head`, wrapping modulo 2^AW. On acceptance, `buf_head` advances by `pay_len` in the same cycle that `udp_rdy` pulses.
- R8: A rejected frame leaves `buf_head` and the peer fields unchanged. The payload of the next accepted frame starts at that unchanged `buf_head`.
- R9: The ring holds at most 2^AW−1 bytes. A datagram whose payload exceeds `buf_rd_ptr − buf_head − 1` (modulo 2^AW) is rejected. No write ever lands at address `buf_rd_ptr − 1`.
- R10: A datagram is rejected if its UDP length is below 8, or if the frame has fewer than 46 + `pay_len` bytes.
- R11: An accepted ARP frame updates only `peer_mac` and `peer_ip`. `peer_port`, `local_port` and `pay_len` keep the values from the last accepted datagram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz receive clock |
| rst | input | 1 | Synchronous active-high reset |
| gmii_rxd | input | 8 | Receive data byte |
| gmii_rx_dv | input | 1 | Receive data valid |
| gmii_rx_er | input | 1 | Receive error |
| local_ip | input | 32 | This node's IPv4 address |
| buf_rd_ptr | input | AW | Reader's next read address in the ring |
| arp_req | output | 1 | One-cycle request to send an ARP reply |
| udp_rdy | output | 1 | One-cycle pulse: a datagram was committed |
| peer_mac | output | 48 | MAC address of the last accepted peer |
| peer_ip | output | 32 | IPv4 address of the last accepted peer |
| peer_port | output | 16 | UDP source port of the last accepted datagram |
| local_port | output | 16 | UDP destination port of the last accepted datagram |
| pay_len | output | 16 | Payload length of the last accepted datagram |
| buf_we | output | 1 | Payload buffer write enable |
| buf_waddr | output | AW | Payload buffer write address |
| buf_wdata | output | 8 | Payload buffer write data |
| buf_head | output | AW | Committed end of payload data in the ring |

## Verification
The hardest case to reach from the ports is a datagram that runs out of ring space in the middle of its payload. The bytes written before the shortfall must vanish, and the next good frame must reuse the same addresses. The bench steers `buf_rd_ptr` to a few bytes past the head. It then sends one payload that fits exactly and one that is a single byte too long. A second hard case is a mid-payload `gmii_rx_er` followed at once by a good frame. Long random runs of good and corrupted datagrams drive the head around the ring boundary, so the wrap gets exercised together with the rollback.

// File: rtl/gur_pkg.sv
package gur_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_BODY, ST_DROP} rx_st_e;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [15:0] ETYPE_ARP  = 16'h0806;
  localparam logic [15:0] ETYPE_IP4  = 16'h0800;
  localparam logic [7:0]  IP_VIHL    = 8'h45;
  localparam logic [7:0]  IP_UDP     = 8'd17;
  localparam logic [15:0] ARP_OP_REQ = 16'd1;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD_RES  = 32'hDEBB20E3;

  // byte index of the last byte of each field, counted from the delimiter
  localparam int OFS_SMAC_END  = 11;
  localparam int OFS_TYPE_END  = 13;
  localparam int OFS_VIHL      = 14;
  localparam int OFS_OPER_END  = 21;
  localparam int OFS_PROTO     = 23;
  localparam int OFS_SIP_END   = 29;
  localparam int OFS_SPA_END   = 31;
  localparam int OFS_DIP_END   = 33;
  localparam int OFS_SPORT_END = 35;
  localparam int OFS_DPORT_END = 37;
  localparam int OFS_ULEN_END  = 39;
  localparam int OFS_TPA_END   = 41;
  localparam int OFS_PAYLOAD   = 42;
  localparam int CSUM_FIRST    = 14;
  localparam int CSUM_LAST     = 33;
  localparam int FCS_BYTES     = 4;
  localparam int UDP_HDR_BYTES = 8;
  localparam int ARP_MIN_BYTES = OFS_TPA_END + 1 + FCS_BYTES;
endpackage

// File: rtl/gur_crc32.sv
module gur_crc32
  import gur_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic       good
);
  logic [31:0] crc_q, crc_nx;

  always_comb begin
    crc_nx = crc_q ^ {24'd0, din};
    for (int b = 0; b < 8; b++)
      crc_nx = crc_nx[0] ? ((crc_nx >> 1) ^ CRC_POLY_REFL) : (crc_nx >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '1;
    else if (en)    crc_q <= crc_nx;
  end

  assign good = (crc_q == CRC_GOOD_RES);
endmodule

// File: rtl/gur_csum16.sv
module gur_csum16 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       hi,
  input  logic [7:0] din,
  output logic       good
);
  logic [15:0] acc_q;
  logic [7:0]  hi_q;
  logic [16:0] sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, hi_q, din};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      hi_q  <= '0;
    end else if (en) begin
      if (hi) hi_q  <= din;
      else    acc_q <= sum[15:0] + {15'd0, sum[16]};
    end
  end

  assign good = (acc_q == 16'hFFFF);
endmodule

// File: rtl/gur_pay_wr.sv
module gur_pay_wr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [7:0]    din,
  input  logic          commit,
  input  logic          abort,
  input  logic [AW-1:0] rd_ptr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] head,
  output logic          ovf
);
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] wptr_inc;

  assign wptr_inc = wptr_q + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      head   <= '0;
      we     <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
      ovf    <= 1'b0;
    end else begin
      we <= 1'b0;
      if (commit) begin
        head <= wptr_q;
        ovf  <= 1'b0;
      end else if (abort) begin
        wptr_q <= head;
        ovf    <= 1'b0;
      end else if (req) begin
        if (ovf || wptr_inc == rd_ptr) begin
          ovf <= 1'b1;
        end else begin
          we     <= 1'b1;
          waddr  <= wptr_q;
          wdata  <= din;
          wptr_q <= wptr_inc;
        end
      end
    end
  end
endmodule

// File: rtl/gmii_udp_rx.sv
module gmii_udp_rx
  import gur_pkg::*;
#(
  parameter int AW = 11,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    gmii_rxd,
  input  logic          gmii_rx_dv,
  input  logic          gmii_rx_er,
  input  logic [31:0]   local_ip,
  input  logic [AW-1:0] buf_rd_ptr,
  output logic          arp_req,
  output logic          udp_rdy,
  output logic [47:0]   peer_mac,
  output logic [31:0]   peer_ip,
  output logic [15:0]   peer_port,
  output logic [15:0]   local_port,
  output logic [15:0]   pay_len,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic [AW-1:0] buf_head
);
  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic [39:0]   sh;
  logic [47:0]   win;
  logic          err;
  logic [47:0]   c_mac;
  logic [31:0]   c_sip, c_tip;
  logic [15:0]   c_type, c_oper, c_sport, c_dport, c_ulen;
  logic [7:0]    c_vihl, c_proto;
  logic          byte_en, at_end, in_body;
  logic          crc_ok, csum_ok, ovf;
  logic          pay_req, len_ok_udp, arp_pass, udp_pass;
  int            ci;

  assign win     = {sh, gmii_rxd};
  assign in_body = (st == ST_BODY);
  assign byte_en = in_body && gmii_rx_dv;
  assign at_end  = in_body && !gmii_rx_dv;
  assign ci      = int'(cnt);

  gur_crc32 u_crc (
    .clk(clk), .rst(rst), .clr(!in_body), .en(byte_en), .din(gmii_rxd), .good(crc_ok)
  );

  gur_csum16 u_csum (
    .clk(clk), .rst(rst), .clr(!in_body),
    .en(byte_en && ci >= CSUM_FIRST && ci <= CSUM_LAST),
    .hi(!cnt[0]), .din(gmii_rxd), .good(csum_ok)
  );

  assign pay_req = byte_en && c_type == ETYPE_IP4 && int'(c_ulen) >= UDP_HDR_BYTES
                && ci >= OFS_PAYLOAD && ci < int'(c_ulen) + OFS_PAYLOAD - UDP_HDR_BYTES;

  gur_pay_wr #(.AW(AW)) u_pay (
    .clk(clk), .rst(rst), .req(pay_req), .din(gmii_rxd),
    .commit(at_end && udp_pass), .abort(at_end && !udp_pass),
    .rd_ptr(buf_rd_ptr), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .head(buf_head), .ovf(ovf)
  );

  assign len_ok_udp = ci >= int'(c_ulen) + OFS_PAYLOAD - UDP_HDR_BYTES + FCS_BYTES;

  assign arp_pass = !err && crc_ok && c_type == ETYPE_ARP && c_oper == ARP_OP_REQ
                 && c_tip == local_ip && ci >= ARP_MIN_BYTES;

  assign udp_pass = !err && crc_ok && c_type == ETYPE_IP4 && c_vihl == IP_VIHL
                 && c_proto == IP_UDP && c_tip == local_ip && csum_ok
                 && int'(c_ulen) >= UDP_HDR_BYTES && len_ok_udp && !ovf;

  // framing and field capture
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      err     <= 1'b0;
      c_mac   <= '0;
      c_sip   <= '0;
      c_tip   <= '0;
      c_type  <= '0;
      c_oper  <= '0;
      c_sport <= '0;
      c_dport <= '0;
      c_ulen  <= '0;
      c_vihl  <= '0;
      c_proto <= '0;
    end else begin
      case (st)
        ST_IDLE: if (gmii_rx_dv) st <= (gmii_rxd == PRE_BYTE) ? ST_PRE : ST_DROP;
        ST_PRE: begin
          if (!gmii_rx_dv) st <= ST_IDLE;
          else if (gmii_rxd == SFD_BYTE) begin
            st  <= ST_BODY;
            cnt <= '0;
            err <= 1'b0;
          end else if (gmii_rxd != PRE_BYTE) st <= ST_DROP;
        end
        ST_BODY: if (!gmii_rx_dv) st <= ST_IDLE;
        default: if (!gmii_rx_dv) st <= ST_IDLE;
      endcase

      if (byte_en) begin
        sh <= win[39:0];
        if (cnt != '1) cnt <= cnt + CW'(1);
        if (gmii_rx_er) err <= 1'b1;
        if (ci == OFS_SMAC_END)  c_mac   <= win;
        if (ci == OFS_TYPE_END)  c_type  <= win[15:0];
        if (ci == OFS_VIHL)      c_vihl  <= gmii_rxd;
        if (ci == OFS_OPER_END)  c_oper  <= win[15:0];
        if (ci == OFS_PROTO)     c_proto <= gmii_rxd;
        if (ci == OFS_SPORT_END) c_sport <= win[15:0];
        if (ci == OFS_DPORT_END) c_dport <= win[15:0];
        if (ci == OFS_ULEN_END)  c_ulen  <= win[15:0];
        if (c_type == ETYPE_IP4) begin
          if (ci == OFS_SIP_END) c_sip <= win[31:0];
          if (ci == OFS_DIP_END) c_tip <= win[31:0];
        end else if (c_type == ETYPE_ARP) begin
          if (ci == OFS_SPA_END) c_sip <= win[31:0];
          if (ci == OFS_TPA_END) c_tip <= win[31:0];
        end
      end
    end
  end

  // verdict and holding registers
  always_ff @(posedge clk) begin
    if (rst) begin
      arp_req    <= 1'b0;
      udp_rdy    <= 1'b0;
      peer_mac   <= '0;
      peer_ip    <= '0;
      peer_port  <= '0;
      local_port <= '0;
      pay_len    <= '0;
    end else begin
      arp_req <= at_end && arp_pass;
      udp_rdy <= at_end && udp_pass;
      if (at_end && (arp_pass || udp_pass)) begin
        peer_mac <= c_mac;
        peer_ip  <= c_sip;
      end
      if (at_end && udp_pass) begin
        peer_port  <= c_sport;
        local_port <= c_dport;
        pay_len    <= c_ulen - 16'(UDP_HDR_BYTES);
      end
    end
  end
endmodule

// File: rtl/gur_rx_chk.sv
module gur_rx_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          arp_req,
  input logic          udp_rdy,
  input logic          buf_we,
  input logic [AW-1:0] buf_waddr,
  input logic [AW-1:0] buf_head,
  input logic [AW-1:0] buf_rd_ptr,
  input logic [31:0]   peer_ip
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst) !(arp_req && udp_rdy)); // R2
  AST_ARP_PULSE: assert property (@(posedge clk) disable iff (rst) arp_req |=> !arp_req); // R3
  AST_UDP_PULSE: assert property (@(posedge clk) disable iff (rst) udp_rdy |=> !udp_rdy); // R4
  AST_WR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |-> buf_waddr == AW'($past(buf_waddr) + AW'(1))); // R7
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst) !udp_rdy |-> $stable(buf_head)); // R8
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> AW'(buf_waddr + AW'(1)) != $past(buf_rd_ptr)); // R9
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!udp_rdy && !arp_req) |-> $stable(peer_ip)); // R11
endmodule

bind gmii_udp_rx gur_rx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .arp_req(arp_req), .udp_rdy(udp_rdy), .buf_we(buf_we),
  .buf_waddr(buf_waddr), .buf_head(buf_head), .buf_rd_ptr(buf_rd_ptr), .peer_ip(peer_ip)
);

// File: tb/test_gmii_udp_rx.sv
module test_gmii_udp_rx;
  localparam int CLK_P = 8;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] MY_IP = 32'hC0A8_010A;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] gmii_rxd = '0;
  logic gmii_rx_dv = 1'b0, gmii_rx_er = 1'b0;
  logic [AW-1:0] buf_rd_ptr = '0;
  logic arp_req, udp_rdy, buf_we;
  logic [47:0] peer_mac;
  logic [31:0] peer_ip;
  logic [15:0] peer_port, local_port, pay_len;
  logic [AW-1:0] buf_waddr, buf_head;
  logic [7:0] buf_wdata;

  always #(CLK_P/2) clk = ~clk;

  gmii_udp_rx #(.AW(AW)) i_gmii_udp_rx (
    .clk(clk), .rst(rst), .gmii_rxd(gmii_rxd), .gmii_rx_dv(gmii_rx_dv), .gmii_rx_er(gmii_rx_er),
    .local_ip(MY_IP), .buf_rd_ptr(buf_rd_ptr), .arp_req(arp_req), .udp_rdy(udp_rdy),
    .peer_mac(peer_mac), .peer_ip(peer_ip), .peer_port(peer_port), .local_port(local_port),
    .pay_len(pay_len), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_head(buf_head)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] fb [0:1599];
  logic [7:0] pl [0:255];
  logic [7:0] mem [0:DEPTH-1];
  int flen;
  logic got_arp, got_udp;
  // model of accepted state
  logic [47:0] e_mac; logic [31:0] e_ip; logic [15:0] e_sport, e_dport, e_plen;
  logic [AW-1:0] e_head;
  // fields of the frame under construction
  logic [47:0] f_mac; logic [31:0] f_ip; logic [15:0] f_sport, f_dport; int f_plen;

  always @(negedge clk) if (buf_we) mem[buf_waddr] = buf_wdata;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c = '1;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [15:0] ip_sum();
    logic [31:0] s = 0;
    for (int i = 14; i < 34; i += 2) s += {fb[i], fb[i+1]};
    while (s[31:16] != 0) s = s[15:0] + s[31:16];
    return ~s[15:0];
  endfunction

  task automatic put16(input int at, input logic [15:0] v);
    fb[at] = v[15:8]; fb[at+1] = v[7:0];
  endtask
  task automatic put32(input int at, input logic [31:0] v);
    put16(at, v[31:16]); put16(at+2, v[15:0]);
  endtask

  task automatic hdr_eth(input logic [15:0] et);
    f_mac = {16'h0200, 32'($urandom)};
    for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
    for (int i = 0; i < 6; i++) fb[6+i] = f_mac[47-8*i -: 8];
    put16(12, et);
  endtask

  task automatic pad_fcs(input bit bad);
    logic [31:0] c;
    while (flen < 60) begin fb[flen] = 8'h00; flen++; end
    c = crc_of(flen);
    if (bad) c = c ^ 32'h0000_0100;
    for (int i = 0; i < 4; i++) fb[flen+i] = c[8*i +: 8];
    flen += 4;
  endtask

  task automatic build_udp(input logic [31:0] dip, input int plen);
    hdr_eth(16'h0800);
    f_ip = $urandom; f_sport = 16'($urandom); f_dport = 16'($urandom); f_plen = plen;
    fb[14] = 8'h45; fb[15] = 8'h00; put16(16, 16'(28 + plen)); put16(18, 16'($urandom));
    put16(20, 16'h4000); fb[22] = 8'h40; fb[23] = 8'd17; put16(24, 16'h0000);
    put32(26, f_ip); put32(30, dip);
    put16(34, f_sport); put16(36, f_dport); put16(38, 16'(8 + plen)); put16(40, 16'h0000);
    for (int i = 0; i < plen; i++) begin pl[i] = 8'($urandom); fb[42+i] = pl[i]; end
    put16(24, ip_sum());
    flen = 42 + plen;
  endtask

  task automatic build_arp(input logic [15:0] op, input logic [31:0] tpa);
    hdr_eth(16'h0806);
    f_ip = $urandom;
    put16(14, 16'h0001); put16(16, 16'h0800); fb[18] = 8'd6; fb[19] = 8'd4; put16(20, op);
    for (int i = 0; i < 6; i++) fb[22+i] = fb[6+i];
    put32(28, f_ip);
    for (int i = 0; i < 6; i++) fb[32+i] = 8'h00;
    put32(38, tpa);
    flen = 42;
  endtask

  task automatic send(input int er_at, input bit bad_pre);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      gmii_rx_dv = 1'b1;
      gmii_rxd = (i == 7) ? 8'hD5 : ((bad_pre && i == 6) ? 8'h5A : 8'h55);
    end
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      gmii_rxd = fb[i]; gmii_rx_er = (i == er_at);
    end
    @(negedge clk);
    gmii_rx_dv = 1'b0; gmii_rx_er = 1'b0; gmii_rxd = 8'h00;
    @(negedge clk);
    got_arp = arp_req; got_udp = udp_rdy;
    repeat (12) @(negedge clk);
  endtask

  // checks after a UDP frame; ok = expected acceptance
  task automatic expect_udp(input bit ok, input string req);
    int bad = 0;
    if (ok) begin
      e_mac = f_mac; e_ip = f_ip; e_sport = f_sport; e_dport = f_dport; e_plen = 16'(f_plen);
      for (int i = 0; i < f_plen; i++)
        if (mem[AW'(e_head + AW'(i))] !== pl[i]) bad++;
      chk(bad == 0, {req, " payload R7"}, 64'(bad), 0);
      e_head = AW'(e_head + AW'(f_plen));
    end
    chk(got_udp == ok && got_arp == 1'b0, {req, " verdict"}, {got_arp, got_udp}, {1'b0, ok});
    chk(buf_head == e_head, {req, " head R8"}, buf_head, e_head);
    chk(peer_ip == e_ip && peer_mac == e_mac, {req, " peer R4"}, peer_ip, e_ip);
    chk(peer_port == e_sport && local_port == e_dport && pay_len == e_plen,
        {req, " ports R11"}, {peer_port, local_port, pay_len}, {e_sport, e_dport, e_plen});
    buf_rd_ptr = e_head;
  endtask

  task automatic expect_arp(input bit ok, input string req);
    if (ok) begin e_mac = f_mac; e_ip = f_ip; end
    chk(got_arp == ok && got_udp == 1'b0, {req, " verdict R3"}, {got_arp, got_udp}, {ok, 1'b0});
    chk(peer_ip == e_ip && peer_mac == e_mac, {req, " peer R3"}, peer_ip, e_ip);
    chk(peer_port == e_sport && pay_len == e_plen && buf_head == e_head, {req, " keep R11"},
        {peer_port, pay_len}, {e_sport, e_plen});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    e_mac = '0; e_ip = '0; e_sport = '0; e_dport = '0; e_plen = '0; e_head = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!arp_req && !udp_rdy && !buf_we && buf_head == 0, "reset", {arp_req, udp_rdy, buf_we}, 0);

    build_udp(MY_IP, 5); pad_fcs(0); send(-1, 0); expect_udp(1, "R4 good udp");
    build_udp(MY_IP, 30); pad_fcs(0); send(-1, 0); expect_udp(1, "R7 unpadded udp");
    build_udp(MY_IP, 0); pad_fcs(0); send(-1, 0); expect_udp(1, "R4 empty payload");
    build_arp(16'd1, MY_IP); pad_fcs(0); send(-1, 0); expect_arp(1, "R3 arp request");
    build_arp(16'd2, MY_IP); pad_fcs(0); send(-1, 0); expect_arp(0, "R3 arp reply opcode");
    build_arp(16'd1, MY_IP ^ 32'h1); pad_fcs(0); send(-1, 0); expect_arp(0, "R3 arp other ip");
    build_arp(16'd1, MY_IP); pad_fcs(1); send(-1, 0); expect_arp(0, "R5 arp bad fcs");
    build_udp(MY_IP, 20); pad_fcs(1); send(-1, 0); expect_udp(0, "R5 udp bad fcs");
    build_udp(MY_IP, 20); pad_fcs(0); send(45, 0); expect_udp(0, "R6 rx_er mid payload");
    build_udp(MY_IP, 12); pad_fcs(0); send(-1, 0); expect_udp(1, "R8 after rollback");
    build_udp(MY_IP, 10); put16(12, 16'h86DD); pad_fcs(0); send(-1, 0); expect_udp(0, "R2 other type");
    build_udp(MY_IP, 10); pad_fcs(0); send(-1, 1); expect_udp(0, "R1 bad preamble");
    build_udp(MY_IP ^ 32'h100, 10); pad_fcs(0); send(-1, 0); expect_udp(0, "R4 other dst ip");
    build_udp(MY_IP, 10); fb[24] ^= 8'h01; pad_fcs(0); send(-1, 0); expect_udp(0, "R4 bad ip csum");
    build_udp(MY_IP, 10); fb[23] = 8'd6; put16(24, 16'h0); put16(24, ip_sum()); pad_fcs(0);
    send(-1, 0); expect_udp(0, "R4 not udp proto");
    build_udp(MY_IP, 10); put16(38, 16'd4); pad_fcs(0); send(-1, 0); expect_udp(0, "R10 short udp len");
    build_udp(MY_IP, 30); put16(38, 16'd48); pad_fcs(0); send(-1, 0); expect_udp(0, "R10 truncated");
    build_udp(MY_IP, 7); pad_fcs(0); send(-1, 0); expect_udp(1, "R1 recovery");

    buf_rd_ptr = AW'(e_head + AW'(5));
    build_udp(MY_IP, 5); pad_fcs(0); send(-1, 0); expect_udp(0, "R9 one byte too long");
    buf_rd_ptr = AW'(e_head + AW'(5));
    build_udp(MY_IP, 4); pad_fcs(0); send(-1, 0); expect_udp(1, "R9 exact fit");

    for (int n = 0; n < 90; n++) begin
      int kind = $urandom_range(0, 5);
      int plen = $urandom_range(0, 90);
      build_udp((kind == 2) ? (MY_IP + 1) : MY_IP, plen);
      pad_fcs(kind == 1);
      send((kind == 3) ? 20 + plen : -1, 0);
      expect_udp(kind != 1 && kind != 2 && kind != 3, "R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule